// File: doc/BRIEF.md
# Paged Serial EEPROM Transaction Controller

This block is the memory command layer of a byte-wide serial EEPROM. A bus framer in front of it detects start and stop conditions, compares the device code and select pins, and deserializes bytes. The framer then hands this block one event per cycle: a start, a stop, an accepted device-select word with its read/write bit, a received byte, or a request for the next read byte. The block answers every select word and received byte with a registered acknowledge or not-acknowledge. It returns read bytes from an internal synchronous array, one cycle after each request.

A write transfer carries two memory-address bytes, high byte first, and then data. The data bytes go into a page buffer, together with a per-byte valid mask. Nothing reaches the array until a stop arrives. The stop starts a timed write cycle of `WC_CYCLES` clocks, during which the block is busy and refuses select words; a master polls for the end of the cycle this way. A current-address counter serves three kinds of read: current-address reads, random reads (a dummy write followed by a repeated start) and sequential reads. A write-protect input blocks every array update.

The FSM states and their transitions are as follows:
- IDLE goes to ADDR_HI on a write select and to READ on a read select.
- ADDR_HI goes to ADDR_LO on a byte.
- ADDR_LO goes to WDATA on a byte.
- WDATA goes to COMMIT on a stop, if at least one byte is buffered. It goes to IDLE on a stop with no byte buffered, and on any start.
- READ goes to IDLE on a start or a stop.
- COMMIT goes to IDLE when its counter expires.

In every state except COMMIT, a start or a stop returns the FSM to IDLE. A start also clears the page buffer.

Top module: `eep_txn_ctrl`

## Requirements
- R1: After reset, `busy_o`, `resp_vld_o` and `rd_vld_o` are all 0.
- R2: In IDLE, a select word gets `resp_vld_o`=1 and `resp_ack_o`=1 in the next cycle. A write select is followed by two address bytes: the first gives address bits above 7 and the second gives bits 7..0. Each address byte is acknowledged the same way.
- R3: Data bytes are buffered and stored at the stop. Each byte goes to `{page, offset}`. The offset starts at address bits `PAGE_W-1..0` and increments only within those bits, wrapping to offset 0 of the same page. A later byte at the same offset overwrites an earlier one.
- R4: Page positions that received no byte keep their previous array contents.
- R5: After a stop that ends a write with at least one data byte, `busy_o` is 1 for exactly `WC_CYCLES` cycles. While busy, select words and bytes are answered with `resp_ack_o`=0, and bytes are not stored. After the cycle ends, select words are acknowledged again.
- R6: A stop after only the two address bytes starts no write cycle: `busy_o` stays 0. The loaded address becomes the current address.
- R7: While `wp_i`=1, no array location changes. Reads return the stored data regardless of `wp_i`.
- R8: After a write, the current address is the last written address plus one within the same page. A write ending on the last byte of a page leaves the current address at the first byte of that page.
- R9: Each read request returns the byte at the current address on `rd_data_o`, with `rd_vld_o`=1 in the next cycle. The full address then increments, wrapping from `2**ADDR_W-1` to 0.
- R10: A random read is a write select, two address bytes, a repeated start and a read select. The first byte returned is the byte at the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write protect; 1 blocks all array updates |
| start_i | input | 1 | Start or repeated start seen by the framer |
| stop_i | input | 1 | Stop seen by the framer |
| devsel_i | input | 1 | Matching device-select word received |
| devsel_rd_i | input | 1 | Read/write bit of that word; 1 means read |
| byte_vld_i | input | 1 | A byte written by the master is on `byte_i` |
| byte_i | input | 8 | Received address or data byte |
| rd_req_i | input | 1 | Framer needs the next read byte |
| busy_o | output | 1 | Timed write cycle in progress |
| resp_vld_o | output | 1 | Acknowledge decision valid |
| resp_ack_o | output | 1 | 1 means acknowledge, 0 means not-acknowledge |
| rd_vld_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |

## Verification
Two functions can fall in the same cycle. The array commit of a timed write cycle can coincide with an incoming poll select word or a stray data byte. The bench provokes this by sending a select word and then a byte in the cycles right after the stop, while the buffered bytes are still being written to the array. It then checks that both are answered with a not-acknowledge. A later read-back of that page shows the committed bytes intact and the stray byte absent. A second overlap is a page-offset wrap in the same write as an overwrite of earlier buffered data; it is judged by reading back the whole page.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_READ,
        ST_COMMIT
    } eep_state_e;
endpackage

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [PAGE_W-1:0] widx,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] ridx,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output logic              any_valid
);
    localparam int PAGE = 1 << PAGE_W;

    logic [7:0]      data_q [PAGE];
    logic [PAGE-1:0] vld_q;

    for (genvar i = 0; i < PAGE; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
            end else if (clr) begin
                vld_q[i] <= 1'b0;
            end else if (wr && widx == PAGE_W'(i)) begin
                vld_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr && widx == PAGE_W'(i)) begin
                data_q[i] <= wdata;
            end
        end
    end

    assign rdata     = data_q[ridx];
    assign rvalid    = vld_q[ridx];
    assign any_valid = |vld_q;
endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/eep_txn_ctrl.sv
module eep_txn_ctrl #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 7,
    parameter int WC_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       devsel_i,
    input  logic       devsel_rd_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       rd_req_i,
    output logic       busy_o,
    output logic       resp_vld_o,
    output logic       resp_ack_o,
    output logic       rd_vld_o,
    output logic [7:0] rd_data_o
);
    import eep_pkg::*;

    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WC_CYCLES + 1);
    localparam int HI_W  = ADDR_W - 8;

    eep_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [HI_W-1:0]   hi_q;
    logic              rd_vld_q, resp_vld_q, resp_ack_q;

    logic       in_commit, wc_done, rd_go, buf_wr, buf_clr, mem_we;
    logic [7:0] buf_rdata;
    logic       buf_rvalid, any_vld;

    assign in_commit = (state_q == ST_COMMIT);
    assign wc_done   = in_commit && (cnt_q == CNT_W'(WC_CYCLES - 1));
    assign rd_go     = rd_req_i && (state_q == ST_READ);
    assign buf_wr    = byte_vld_i && (state_q == ST_WDATA);
    assign buf_clr   = (!in_commit && start_i)
                     || (byte_vld_i && state_q == ST_ADDR_LO) || wc_done;
    assign mem_we    = in_commit && (cnt_q < CNT_W'(PAGE)) && buf_rvalid && !wp_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (devsel_i) state_d = devsel_rd_i ? ST_READ : ST_ADDR_HI;
            ST_ADDR_HI: if (byte_vld_i) state_d = ST_ADDR_LO;
            ST_ADDR_LO: if (byte_vld_i) state_d = ST_WDATA;
            ST_WDATA:   state_d = ST_WDATA;
            ST_READ:    state_d = ST_READ;
            ST_COMMIT:  if (wc_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (!in_commit) begin
            if (start_i) begin
                state_d = ST_IDLE;
            end else if (stop_i) begin
                state_d = (state_q == ST_WDATA && any_vld) ? ST_COMMIT : ST_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers: write-cycle counter, address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cur_addr_q <= '0;
            hi_q       <= '0;
        end else begin
            cnt_q <= in_commit ? cnt_q + 1'b1 : '0;
            if (byte_vld_i && state_q == ST_ADDR_HI) begin
                hi_q <= byte_i[HI_W-1:0];
            end
            if (byte_vld_i && state_q == ST_ADDR_LO) begin
                cur_addr_q <= {hi_q, byte_i};
            end else if (buf_wr) begin
                cur_addr_q <= {cur_addr_q[ADDR_W-1:PAGE_W], cur_addr_q[PAGE_W-1:0] + 1'b1};
            end else if (rd_go) begin
                cur_addr_q <= cur_addr_q + 1'b1;
            end
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_vld_q <= 1'b0;
            resp_ack_q <= 1'b0;
            rd_vld_q   <= 1'b0;
        end else begin
            resp_vld_q <= (devsel_i && (state_q == ST_IDLE || in_commit))
                       || (byte_vld_i && (state_q == ST_ADDR_HI || state_q == ST_ADDR_LO
                                          || state_q == ST_WDATA || in_commit));
            resp_ack_q <= !in_commit;
            rd_vld_q   <= rd_go;
        end
    end

    assign busy_o     = in_commit;
    assign resp_vld_o = resp_vld_q;
    assign resp_ack_o = resp_ack_q;
    assign rd_vld_o   = rd_vld_q;

    eep_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr        (buf_wr),
        .widx      (cur_addr_q[PAGE_W-1:0]),
        .wdata     (byte_i),
        .ridx      (cnt_q[PAGE_W-1:0]),
        .rdata     (buf_rdata),
        .rvalid    (buf_rvalid),
        .any_valid (any_vld)
    );

    eep_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({cur_addr_q[ADDR_W-1:PAGE_W], cnt_q[PAGE_W-1:0]}),
        .wdata (buf_rdata),
        .re    (rd_go),
        .raddr (cur_addr_q),
        .rdata (rd_data_o)
    );

    // R5
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_i && busy_o) |=> (resp_vld_o && !resp_ack_o));
    // R5
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));
    // R6
    addr_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && state_q == ST_WDATA && !any_vld) |=> !busy_o);
    // R7
    wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |-> !mem_we);
    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> cur_addr_q[ADDR_W-1:PAGE_W] == $past(cur_addr_q[ADDR_W-1:PAGE_W]));
    // R9
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (rd_vld_o && cur_addr_q == $past(cur_addr_q) + 1'b1));
endmodule

// File: tb/eep_txn_ctrl_bench.sv
module eep_txn_ctrl_bench;
    localparam int AW    = 10;
    localparam int PW    = 4;
    localparam int WC    = 40;
    localparam int DEPTH = 1 << AW;
    localparam int PG    = 1 << PW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
    logic       devsel_i = 1'b0, devsel_rd_i = 1'b0, byte_vld_i = 1'b0, rd_req_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       busy_o, resp_vld_o, resp_ack_o, rd_vld_o;
    logic [7:0] rd_data_o;

    int n_chk = 0, n_err = 0;
    int cur_m = 0;
    logic [7:0] mem_m [DEPTH];

    always #2.5 clk = ~clk;

    eep_txn_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .WC_CYCLES(WC)) u_eep_txn_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .start_i(start_i), .stop_i(stop_i),
        .devsel_i(devsel_i), .devsel_rd_i(devsel_rd_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .rd_req_i(rd_req_i), .busy_o(busy_o), .resp_vld_o(resp_vld_o),
        .resp_ack_o(resp_ack_o), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o));

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ev_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask

    task automatic ev_stop();
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic ev_dev(input logic rd, input logic exp_ack, input string tag);
        devsel_i = 1'b1; devsel_rd_i = rd; @(negedge clk);
        devsel_i = 1'b0; devsel_rd_i = 1'b0;
        chk(resp_vld_o && resp_ack_o == exp_ack, tag, {resp_vld_o, resp_ack_o}, {1'b1, exp_ack});
    endtask

    task automatic ev_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        byte_vld_i = 1'b1; byte_i = b; @(negedge clk);
        byte_vld_i = 1'b0;
        chk(resp_vld_o && resp_ack_o == exp_ack, tag, {resp_vld_o, resp_ack_o}, {1'b1, exp_ack});
    endtask

    task automatic count_busy(input int exp, input string tag);
        int c = 0;
        while (busy_o && c < 1000) begin c++; @(negedge clk); end
        chk(c == exp, tag, c, exp);
    endtask

    // Write n bytes starting at addr; byte k = seed + 7*k
    task automatic wr_burst(input int addr, input int n, input int seed, input string tag);
        int base = addr & ~(PG - 1);
        ev_start();
        ev_dev(1'b0, 1'b1, "R2 write select");
        ev_byte(8'(addr >> 8), 1'b1, "R2 addr hi");
        ev_byte(8'(addr), 1'b1, "R2 addr lo");
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = 8'(seed + 7 * k);
            ev_byte(d, 1'b1, tag);
            if (!wp_i) mem_m[base + ((addr + k) % PG)] = d;
        end
        ev_stop();
        count_busy((n > 0) ? WC : 0, (n > 0) ? "R5 busy length" : "R6 no busy");
        cur_m = (n > 0) ? base + ((addr + n) % PG) : addr;
    endtask

    task automatic rd_bytes(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            rd_req_i = 1'b1; @(negedge clk); rd_req_i = 1'b0;
            chk(rd_vld_o && rd_data_o == mem_m[cur_m], tag, rd_data_o, mem_m[cur_m]);
            cur_m = (cur_m + 1) % DEPTH;
        end
    endtask

    task automatic rd_cur(input int n, input string tag);
        ev_start();
        ev_dev(1'b1, 1'b1, "R2 read select");
        rd_bytes(n, tag);
        ev_stop();
    endtask

    task automatic rd_rand(input int addr, input int n, input string tag);
        ev_start();
        ev_dev(1'b0, 1'b1, "R10 dummy write select");
        ev_byte(8'(addr >> 8), 1'b1, "R10 addr hi");
        ev_byte(8'(addr), 1'b1, "R10 addr lo");
        ev_start();
        ev_dev(1'b1, 1'b1, "R10 read select");
        cur_m = addr;
        rd_bytes(n, tag);
        ev_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !resp_vld_o && !rd_vld_o, "R1 reset outputs",
            {busy_o, resp_vld_o, rd_vld_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill whole array, page by page (R2, R3, R5)
        for (int p = 0; p < DEPTH / PG; p++) wr_burst(p * PG, PG, p * 13 + 1, "R3 fill data ack");

        // R10 random read then R9 sequential sweep of whole array
        rd_rand(0, DEPTH, "R9 sequential sweep");
        // R9 wrap from top to 0
        rd_rand(DEPTH - 2, 4, "R9 read wrap");

        // R3 in-page wrap
        wr_burst(5 * PG + 14, 4, 8'hA0, "R3 wrap data ack");
        rd_rand(5 * PG, PG, "R3 page wrap readback");
        // R3 overwrite of earlier buffered bytes
        wr_burst(6 * PG, PG + 2, 8'h33, "R3 overwrite data ack");
        rd_rand(6 * PG, PG, "R3 overwrite readback");
        // R4 partial page keeps old bytes
        wr_burst(7 * PG + 5, 2, 8'h5C, "R4 partial data ack");
        rd_rand(7 * PG, PG, "R4 untouched bytes");

        // R8 current address after write ending at last page byte
        wr_burst(8 * PG + 12, 4, 8'hC1, "R8 data ack");
        chk(cur_m == 8 * PG, "R8 model current address", cur_m, 8 * PG);
        rd_cur(3, "R8 current-address read");

        // R5 poll during write cycle, plus stray byte while committing
        ev_start();
        ev_dev(1'b0, 1'b1, "R2 write select");
        ev_byte(8'((10 * PG) >> 8), 1'b1, "R2 addr hi");
        ev_byte(8'(10 * PG), 1'b1, "R2 addr lo");
        ev_byte(8'h77, 1'b1, "R5 data ack");
        mem_m[10 * PG] = 8'h77;
        ev_stop();
        chk(busy_o, "R5 busy after stop", busy_o, 1);
        ev_dev(1'b0, 1'b0, "R5 poll nack while busy");
        ev_byte(8'hEE, 1'b0, "R5 byte nack while busy");
        count_busy(WC - 2, "R5 remaining busy");
        ev_dev(1'b0, 1'b1, "R5 poll ack after cycle");
        ev_stop();
        rd_rand(10 * PG, PG, "R5 committed page intact");

        // R7 write protect
        wp_i = 1'b1;
        wr_burst(9 * PG, PG, 8'h99, "R7 data ack under wp");
        rd_rand(9 * PG, PG, "R7 protected page unchanged");
        wp_i = 1'b0;

        // R6 stop after address only
        ev_start();
        ev_dev(1'b0, 1'b1, "R6 write select");
        ev_byte(8'((3 * PG + 7) >> 8), 1'b1, "R6 addr hi");
        ev_byte(8'(3 * PG + 7), 1'b1, "R6 addr lo");
        ev_stop();
        chk(!busy_o, "R6 busy after addr-only stop", busy_o, 0);
        @(negedge clk);
        chk(!busy_o, "R6 busy stays low", busy_o, 0);
        cur_m = 3 * PG + 7;
        rd_cur(2, "R6 loaded address read");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule